// File: doc/BRIEF.md
# Cipher engine control sequencer

This block is the control front end of a block-cipher accelerator. Software, or a DMA engine, reaches it through a simple word-wide register bus. Over that bus it loads the key words, the IV words, a configuration word, and the plaintext or ciphertext words. The block keeps its data words in an 8-word input FIFO and an 8-word output FIFO. A separate cipher core does the arithmetic. The sequencer hands that core one whole block at a time through a start/done handshake, then writes the result words back into the output FIFO in a single cycle.

A four-state machine drives the work. The states are S_IDLE, S_KPREP (key preparation running), S_RUN (core processing a block) and S_PARK (a finished result waiting for output space). The transitions are:

- S_IDLE to S_KPREP when the engine is enabled in the key-preparation mode.
- S_IDLE to S_RUN when the engine is enabled and a whole block is queued.
- S_KPREP to S_IDLE on done, which also clears the enable bit.
- S_RUN to S_IDLE on done when the output FIFO has room.
- S_RUN to S_PARK on done when the output FIFO has no room.
- S_PARK to S_IDLE once room appears and no block is staged.
- S_PARK to S_RUN once room appears and a block is staged. The staged block starts at once.

While in S_PARK, one further complete block may be pulled out of the input FIFO early and held.

Top module: `cipher_ctrl_seq`

## Requirements
- R1: After reset, every register reads 0. The status word reads 0x05, meaning both FIFOs are empty and the engine is not busy.
- R2: While busy, bus writes to the key words (addresses 8..15), the IV words (16..19) and the configuration field (control bits [9:2]) are dropped, and the stored values stay unchanged. The enable bit (control bit 15) stays writable.
- R3: If enable is cleared while a block is in flight, that block still completes and its result words reach the output FIFO. Busy falls only after that, and no further block starts.
- R4: When a result is done but the output FIFO lacks room for it, busy stays high. If the input FIFO then holds another complete block and the engine is enabled, that block is popped and staged, and it starts as soon as the parked result has been written.
- R5: The mode code 3'b111 (control bits [5:3]) selects key preparation. Enabling in this mode issues a core start and raises busy. On done, busy falls, the enable bit clears itself, and nothing is written to the output FIFO.
- R6: Writing 1 to control bit 14 empties both FIFOs. The bit reads back as 0.
- R7: A block is 4 words when mode bit 5 is 1 (AES) and 2 words when it is 0 (DES/TDES). A block starts only when enable is 1 and at least one whole block is in the input FIFO. Input words are written at address 3, and output words are read, with a pop, at address 4.
- R8: The input DMA request is high when the input-request enable (DMA register bit 0) is set and the input FIFO has free space for one burst. A burst is 4 words in AES modes. In DES modes it is 2 words, or 4 words when DMA register bit 2 is set.
- R9: The output DMA request is high when the output-request enable (DMA register bit 1) is set and the output FIFO holds at least one burst.
- R10: The status register (address 1) holds the following flags: bit 0 input empty, bit 1 input full, bit 2 output empty, bit 3 output full, bit 4 busy.
- R11: On core start, the core receives the queued block (the first word written goes in bits [31:0]), the current mode and the direction (control bit 2). The start comes one cycle after the cycle in which the enable write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Read strobe; pops the output FIFO at the data-out address |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| core_start | output | 1 | One-cycle start pulse to the cipher core |
| core_mode | output | 3 | Algorithm and chaining code |
| core_dir | output | 1 | Direction: 0 encrypt, 1 decrypt |
| core_key | output | 256 | Key words |
| core_iv | output | 128 | IV words |
| core_din | output | 128 | Block handed to the core |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_dout | input | 128 | Result block from the core |
| dma_in_req | output | 1 | Input DMA burst request |
| dma_out_req | output | 1 | Output DMA burst request |

## Verification
A write is captured on a clock edge. Register readback, the status flags and both DMA requests reflect it as soon as that edge has passed, so the bench reads or samples them at the following falling edge. The core start pulse comes one edge later than that, so the bench checks it two falling edges after it drives the enable write. Result words enter the output FIFO on the edge at which done is sampled, provided there is room. Because the core latency is a bench setting, the bench waits for results by polling the status word until busy falls or the output FIFO stops being empty, bounded by a timeout. It compares each popped word with a value it computes from the input word and key word 0.

// File: rtl/csq_pkg.sv
package csq_pkg;
    localparam int WORD_W  = 32;
    localparam int BLK_MAX = 4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_KPREP = 2'd1,
        S_RUN   = 2'd2,
        S_PARK  = 2'd3
    } csq_state_t;

    localparam logic [2:0] MODE_KPREP = 3'b111;

    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_DMA  = 2;
    localparam int A_DIN  = 3;
    localparam int A_DOUT = 4;
    localparam int A_KEY0 = 8;
    localparam int A_IV0  = 16;

    localparam int B_FLUSH = 14;
    localparam int B_EN    = 15;
endpackage

// File: rtl/csq_fifo.sv
module csq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    parameter int PMAX  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [$clog2(DEPTH+1)-1:0]    push_n,
    input  logic [PMAX*W-1:0]             push_data,
    input  logic [$clog2(DEPTH+1)-1:0]    pop_n,
    output logic [PMAX*W-1:0]             pop_data,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    generate
        for (genvar g = 0; g < PMAX; g++) begin : g_head
            assign pop_data[g*W +: W] = mem[rptr + AW'(g)];
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int i = 0; i < PMAX; i++)
            if (i < int'(push_n)) mem[wptr + AW'(i)] <= push_data[i*W +: W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + AW'(push_n);
            rptr  <= rptr + AW'(pop_n);
            count <= count + push_n - pop_n;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(count) + int'(push_n) - int'(pop_n) <= DEPTH));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(count));
endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
    import csq_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    kprep_mode,
    input  logic [CW-1:0]           bw,
    input  logic [CW-1:0]           in_cnt,
    input  logic [CW-1:0]           out_free,
    input  logic [BLK_MAX*WORD_W-1:0] in_head,
    input  logic                    core_done,
    input  logic [BLK_MAX*WORD_W-1:0] core_dout,
    output logic [CW-1:0]           in_pop_n,
    output logic [CW-1:0]           out_push_n,
    output logic [BLK_MAX*WORD_W-1:0] out_push_data,
    output logic                    core_start,
    output logic [BLK_MAX*WORD_W-1:0] din_q,
    output logic                    en_clr,
    output logic                    busy
);
    csq_state_t state, st_n;
    logic [BLK_MAX*WORD_W-1:0] res_q, nxt_q;
    logic nxt_v;
    logic have_blk, room;
    logic pop, push, sel_res, start, ld_fifo, ld_nxt, latch, stage;

    assign have_blk = in_cnt >= bw;
    assign room     = out_free >= bw;
    assign busy     = state != S_IDLE;

    always_comb begin
        st_n = state; pop = 1'b0; push = 1'b0; sel_res = 1'b0; start = 1'b0;
        ld_fifo = 1'b0; ld_nxt = 1'b0; latch = 1'b0; stage = 1'b0; en_clr = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (en && kprep_mode) begin
                    st_n = S_KPREP; start = 1'b1;
                end else if (en && have_blk) begin
                    st_n = S_RUN; pop = 1'b1; start = 1'b1; ld_fifo = 1'b1;
                end
            end
            S_KPREP: begin
                if (core_done) begin
                    st_n = S_IDLE; en_clr = 1'b1;
                end
            end
            S_RUN: begin
                if (core_done) begin
                    if (room) begin
                        push = 1'b1; st_n = S_IDLE;
                    end else begin
                        latch = 1'b1; st_n = S_PARK;
                    end
                end
            end
            S_PARK: begin
                if (room) begin
                    push = 1'b1; sel_res = 1'b1;
                    if (nxt_v) begin
                        st_n = S_RUN; start = 1'b1; ld_nxt = 1'b1;
                    end else begin
                        st_n = S_IDLE;
                    end
                end else if (en && !nxt_v && have_blk) begin
                    pop = 1'b1; stage = 1'b1;
                end
            end
        endcase
    end

    assign in_pop_n      = pop  ? bw : '0;
    assign out_push_n    = push ? bw : '0;
    assign out_push_data = sel_res ? res_q : core_dout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_start <= 1'b0;
            din_q      <= '0;
            res_q      <= '0;
            nxt_q      <= '0;
            nxt_v      <= 1'b0;
        end else begin
            core_start <= start;
            if (ld_fifo) din_q <= in_head;
            if (ld_nxt) begin
                din_q <= nxt_q;
                nxt_v <= 1'b0;
            end
            if (latch) res_q <= core_dout;
            if (stage) begin
                nxt_q <= in_head;
                nxt_v <= 1'b1;
            end
        end
    end

    assert_idle_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !en) |=> (state == S_IDLE && !core_start));
    assert_park_holds_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PARK && out_free < bw) |=> busy);
    assert_kprep_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_KPREP) |-> (out_push_n == '0));
    assert_done_leaves_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && core_done) |=> (state != S_RUN || $past(nxt_v) == 1'b0));
endmodule

// File: rtl/cipher_ctrl_seq.sv
module cipher_ctrl_seq
    import csq_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int KEY_WORDS = 8,
    parameter int IV_WORDS  = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic                          reg_rd,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [WORD_W-1:0]             reg_wdata,
    output logic [WORD_W-1:0]             reg_rdata,
    output logic                          core_start,
    output logic [2:0]                    core_mode,
    output logic                          core_dir,
    output logic [KEY_WORDS*WORD_W-1:0]   core_key,
    output logic [IV_WORDS*WORD_W-1:0]    core_iv,
    output logic [BLK_MAX*WORD_W-1:0]     core_din,
    input  logic                          core_done,
    input  logic [BLK_MAX*WORD_W-1:0]     core_dout,
    output logic                          dma_in_req,
    output logic                          dma_out_req
);
    localparam int CW = $clog2(DEPTH+1);

    logic              busy, en_q, en_clr;
    logic [7:0]        cfg_q;
    logic              dien_q, doen_q, db4_q;
    logic [WORD_W-1:0] key_q [KEY_WORDS];
    logic [WORD_W-1:0] iv_q  [IV_WORDS];
    logic              wr_ctrl, wr_dma, flush, in_push, out_pop;
    logic [CW-1:0]     in_cnt, out_cnt, out_free, in_free, bw, burst;
    logic [CW-1:0]     in_pop_n, out_push_n;
    logic [BLK_MAX*WORD_W-1:0] in_head, out_head, out_push_data;

    assign wr_ctrl   = reg_wr && int'(reg_addr) == A_CTRL;
    assign wr_dma    = reg_wr && int'(reg_addr) == A_DMA;
    assign flush     = wr_ctrl && reg_wdata[B_FLUSH];
    assign in_push   = reg_wr && int'(reg_addr) == A_DIN && int'(in_cnt) < DEPTH;
    assign out_pop   = reg_rd && int'(reg_addr) == A_DOUT && out_cnt != '0;
    assign core_mode = cfg_q[3:1];
    assign core_dir  = cfg_q[0];
    assign bw        = core_mode[2] ? CW'(4) : CW'(2);
    assign burst     = (core_mode[2] || db4_q) ? CW'(4) : CW'(2);
    assign out_free  = CW'(DEPTH) - out_cnt;
    assign in_free   = CW'(DEPTH) - in_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; cfg_q <= '0;
            dien_q <= 1'b0; doen_q <= 1'b0; db4_q <= 1'b0;
            for (int k = 0; k < KEY_WORDS; k++) key_q[k] <= '0;
            for (int k = 0; k < IV_WORDS; k++)  iv_q[k]  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= reg_wdata[B_EN];
                if (!busy) cfg_q <= reg_wdata[9:2];
            end
            if (en_clr) en_q <= 1'b0;
            if (wr_dma) begin
                dien_q <= reg_wdata[0]; doen_q <= reg_wdata[1]; db4_q <= reg_wdata[2];
            end
            for (int k = 0; k < KEY_WORDS; k++)
                if (reg_wr && !busy && int'(reg_addr) == A_KEY0 + k) key_q[k] <= reg_wdata;
            for (int k = 0; k < IV_WORDS; k++)
                if (reg_wr && !busy && int'(reg_addr) == A_IV0 + k) iv_q[k] <= reg_wdata;
        end
    end

    generate
        for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
            assign core_key[g*WORD_W +: WORD_W] = key_q[g];
        end
        for (genvar g = 0; g < IV_WORDS; g++) begin : g_iv
            assign core_iv[g*WORD_W +: WORD_W] = iv_q[g];
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            A_CTRL: reg_rdata = {16'b0, en_q, 5'b0, cfg_q, 2'b0};
            A_STAT: reg_rdata = {27'b0, busy, out_cnt == CW'(DEPTH), out_cnt == '0,
                                 in_cnt == CW'(DEPTH), in_cnt == '0};
            A_DMA:  reg_rdata = {29'b0, db4_q, doen_q, dien_q};
            A_DOUT: reg_rdata = out_head[WORD_W-1:0];
            default: begin
                for (int k = 0; k < KEY_WORDS; k++)
                    if (int'(reg_addr) == A_KEY0 + k) reg_rdata = key_q[k];
                for (int k = 0; k < IV_WORDS; k++)
                    if (int'(reg_addr) == A_IV0 + k) reg_rdata = iv_q[k];
            end
        endcase
    end

    assign dma_in_req  = dien_q && in_free >= burst;
    assign dma_out_req = doen_q && out_cnt >= burst;

    csq_fifo #(.W(WORD_W), .DEPTH(DEPTH), .PMAX(BLK_MAX)) u_in_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(in_push ? CW'(1) : CW'(0)),
        .push_data({{((BLK_MAX-1)*WORD_W){1'b0}}, reg_wdata}),
        .pop_n(in_pop_n), .pop_data(in_head), .count(in_cnt)
    );

    csq_fifo #(.W(WORD_W), .DEPTH(DEPTH), .PMAX(BLK_MAX)) u_out_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_n(out_push_n), .push_data(out_push_data),
        .pop_n(out_pop ? CW'(1) : CW'(0)), .pop_data(out_head), .count(out_cnt)
    );

    csq_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .kprep_mode(core_mode == MODE_KPREP),
        .bw(bw), .in_cnt(in_cnt), .out_free(out_free), .in_head(in_head),
        .core_done(core_done), .core_dout(core_dout),
        .in_pop_n(in_pop_n), .out_push_n(out_push_n), .out_push_data(out_push_data),
        .core_start(core_start), .din_q(core_din), .en_clr(en_clr), .busy(busy)
    );

    assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl) |=> $stable(cfg_q));
    assert_key_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && int'(reg_addr) == A_KEY0) |=> $stable(key_q[0]));
    assert_en_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_q);
endmodule

// File: tb/sim_cipher_ctrl_seq.sv
module sim_cipher_ctrl_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         core_start, core_dir;
    logic [2:0]   core_mode;
    logic [255:0] core_key;
    logic [127:0] core_iv, core_din;
    logic         core_done = 1'b0;
    logic [127:0] core_dout = '0;
    logic         dma_in_req, dma_out_req;

    int n_chk = 0, n_fail = 0;
    int lat = 3;
    logic [31:0] kv = 32'h1234_5678;
    logic [31:0] expq [$];
    logic [127:0] stub_buf = '0;
    int  stub_cnt = 0;
    bit  stub_act = 1'b0;

    always #5 clk = ~clk;

    cipher_ctrl_seq u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_start(core_start),
        .core_mode(core_mode), .core_dir(core_dir), .core_key(core_key), .core_iv(core_iv),
        .core_din(core_din), .core_done(core_done), .core_dout(core_dout),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    // stand-in core: fixed transform after lat cycles
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (core_start) begin
            stub_buf <= core_din; stub_cnt <= lat; stub_act <= 1'b1;
        end else if (stub_act) begin
            if (stub_cnt <= 1) begin
                core_done <= 1'b1; stub_act <= 1'b0;
                for (int i = 0; i < 4; i++)
                    core_dout[i*32 +: 32] <= stub_buf[i*32 +: 32] ^ 32'hFFFF_0000 ^ core_key[31:0];
            end else stub_cnt <= stub_cnt - 1;
        end
    end

    function automatic logic [31:0] xf(logic [31:0] w);
        return w ^ 32'hFFFF_0000 ^ kv;
    endfunction

    function automatic logic [31:0] cw(bit en, logic [2:0] mode, bit dir);
        return (32'(en) << 15) | (32'(mode) << 3) | (32'(dir) << 2);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d, input bit pop);
        @(negedge clk); reg_addr = 5'(a); #1 d = reg_rdata; reg_rd = pop;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic push(logic [31:0] w);
        wr(3, w); expq.push_back(xf(w));
    endtask

    task automatic wait_stat(string req, bit need_in_empty);
        logic [31:0] s;
        for (int t = 0; t < 2000; t++) begin
            rd(1, s, 1'b0);
            if (!s[4] && (!need_in_empty || s[0])) return;
        end
        check(req, s, 32'hFFFF_FFFF);
    endtask

    task automatic drain(string req, int n);
        logic [31:0] s, d;
        for (int k = 0; k < n; k++) begin
            for (int t = 0; t < 2000; t++) begin
                rd(1, s, 1'b0);
                if (!s[2]) break;
            end
            rd(4, d, 1'b1);
            check(req, d, expq.pop_front());
        end
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 R10 reset state
        rd(1, r, 0); check("R1 status", r, 32'h05);
        rd(0, r, 0); check("R1 ctrl", r, 0);
        rd(8, r, 0); check("R1 key0", r, 0);

        // R6 flush
        wr(3, 1); wr(3, 2); wr(3, 3);
        rd(1, r, 0); check("R10 in not empty", r, 32'h04);
        wr(0, 32'h1 << 14);
        rd(1, r, 0); check("R6 flushed", r, 32'h05);
        rd(0, r, 0); check("R6 flush reads 0", r, 0);

        wr(8, kv); wr(16, 32'hC0DE_0001);
        rd(16, r, 0); check("R11 iv0", r, 32'hC0DE_0001);

        // R7 R11 sweep over block size and direction
        for (int m = 0; m < 2; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [2:0] mode = (m == 1) ? 3'b100 : 3'b000;
                int bwd = (m == 1) ? 4 : 2;
                wr(0, cw(0, mode, dir[0]));
                for (int b = 0; b < 2; b++)
                    for (int i = 0; i < bwd; i++)
                        push(32'hA000_0000 + (m << 16) + (dir << 12) + (b << 8) + i);
                repeat (4) @(negedge clk);
                rd(1, r, 0); check("R7 no start while disabled", r[4], 0);
                wr(0, cw(1, mode, dir[0]));
                @(negedge clk);
                check("R11 start one cycle after enable", core_start, 1);
                check("R11 mode", core_mode, mode);
                check("R11 dir", core_dir, dir[0]);
                check("R11 word order", core_din[31:0], 32'hA000_0000 + (m << 16) + (dir << 12));
                wait_stat("R7 idle", 1);
                drain("R7 results", 2 * bwd);
                rd(1, r, 0); check("R10 all empty", r, 32'h05);
                wr(0, cw(0, mode, dir[0]));
            end
        end

        // R7 partial block does not start
        wr(0, cw(1, 3'b000, 0));
        push(32'h5555_0001);
        repeat (10) @(negedge clk);
        rd(1, r, 0); check("R7 partial block idle", r, 32'h04);
        push(32'h5555_0002);
        wait_stat("R7 second word", 1);
        drain("R7 partial then full", 2);
        wr(0, cw(0, 3'b000, 0));

        // R2 lockout while busy
        lat = 30;
        wr(0, cw(0, 3'b100, 0));
        for (int i = 0; i < 4; i++) push(32'hB000_0000 + i);
        wr(0, cw(1, 3'b100, 0));
        rd(1, r, 0); check("R2 busy", r[4], 1);
        wr(8, 32'hDEAD_BEEF);
        wr(16, 32'hDEAD_0000);
        wr(0, cw(1, 3'b001, 1));
        rd(8, r, 0); check("R2 key kept", r, kv);
        rd(16, r, 0); check("R2 iv kept", r, 32'hC0DE_0001);
        rd(0, r, 0); check("R2 cfg kept", r, cw(1, 3'b100, 0));
        wait_stat("R2 idle", 1);
        drain("R2 result", 4);
        wr(0, cw(0, 3'b100, 0));
        kv = 32'h0F0F_0F0F; wr(8, kv);
        rd(8, r, 0); check("R2 key writable when idle", r, kv);

        // R3 disable while busy
        for (int i = 0; i < 8; i++) begin
            if (i < 4) push(32'hC000_0000 + i);
            else wr(3, 32'hC000_0000 + i);
        end
        wr(0, cw(1, 3'b100, 0));
        wr(0, cw(0, 3'b100, 0));
        rd(1, r, 0); check("R3 still busy", r[4], 1);
        wait_stat("R3 finish", 0);
        rd(1, r, 0); check("R3 one block out, one held", r, 32'h00);
        drain("R3 result", 4);
        wr(0, 32'h1 << 14);

        // R4 early pop while output full
        lat = 3;
        wr(0, cw(0, 3'b000, 0));
        for (int i = 0; i < 8; i++) push(32'hD000_0000 + i);
        wr(0, cw(1, 3'b000, 0));
        wait_stat("R4 fill", 1);
        rd(1, r, 0); check("R4 out full", r, 32'h09);
        push(32'hD000_0100); push(32'hD000_0101);
        push(32'hD000_0200); push(32'hD000_0201);
        repeat (20) @(negedge clk);
        rd(1, r, 0); check("R4 staged, busy, out full", r, 32'h19);
        drain("R4 order", 12);
        wait_stat("R4 idle", 1);
        rd(1, r, 0); check("R4 end", r, 32'h05);
        wr(0, cw(0, 3'b000, 0));

        // R5 key preparation
        lat = 5;
        wr(0, cw(0, 3'b111, 0));
        wr(0, cw(1, 3'b111, 0));
        @(negedge clk);
        check("R5 start", core_start, 1);
        rd(1, r, 0); check("R5 busy", r, 32'h15);
        wait_stat("R5 done", 1);
        rd(0, r, 0); check("R5 enable cleared", r, cw(0, 3'b111, 0));
        rd(1, r, 0); check("R5 no output", r, 32'h05);

        // R8 input DMA request
        wr(0, cw(0, 3'b100, 0));
        wr(2, 1);
        check("R8 empty fifo", dma_in_req, 1);
        for (int i = 0; i < 5; i++) wr(3, i);
        check("R8 aes free 3", dma_in_req, 0);
        wr(0, cw(0, 3'b000, 0));
        check("R8 des burst 2", dma_in_req, 1);
        wr(2, 5);
        check("R8 des burst 4", dma_in_req, 0);
        wr(2, 0); wr(0, 32'h1 << 14);
        check("R8 disabled", dma_in_req, 0);

        // R9 output DMA request
        wr(0, cw(0, 3'b100, 0));
        for (int i = 0; i < 4; i++) push(32'hE000_0000 + i);
        wr(0, cw(1, 3'b100, 0));
        wait_stat("R9 idle", 1);
        wr(0, cw(0, 3'b100, 0));
        check("R9 not enabled", dma_out_req, 0);
        wr(2, 2);
        check("R9 four words", dma_out_req, 1);
        drain("R9 word", 1);
        check("R9 three words aes", dma_out_req, 0);
        wr(0, cw(0, 3'b000, 0));
        check("R9 three words des", dma_out_req, 1);
        drain("R9 rest", 3);
        check("R9 empty", dma_out_req, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule